// File: doc/BRIEF.md
# Three-Mode Serial Port

This block is a compact serial port for a small controller core. A two-bit mode input selects one of three framings that share a single host-side interface. Mode 0 is a synchronous shifter. The port drives a shift clock on `txd` and moves eight bits, least significant first, over a data pin that is bidirectional (`rxd_in`, `rxd_out` and `rxd_oe`). Mode 1 is a 10-bit asynchronous frame paced by externally supplied oversampling ticks. Mode 2 is an 11-bit asynchronous frame. Its ninth bit is programmable, and its rate is derived from the core clock.

Outgoing bytes enter through a valid/ready pair. A byte is taken only while the port is idle, and taking it starts the frame at once. There is no queue, so a producer holds `tx_valid` and `tx_data` until `tx_ready` returns. Received bytes leave through a second valid/ready pair. `rx_valid` is the sticky receive flag. While it is high, `rx_data` and `rb8` are frozen, and any further frame that completes is thrown away. A cycle with `rx_valid && rx_ready` consumes the byte. The flag `ti` reports that a frame has been sent, and it stays high until `ti_clr` is pulsed.

The receive side applies an acceptance gate. When `sm2` is set, a frame is kept only if its ninth bit (the stop bit in mode 1) is 1. A node on a multi-drop bus can therefore ignore data frames until it has been addressed.

Top module: `mcu_serial_port`

## Requirements
- R1: `mode` = {hi,lo}: 2'b00 selects synchronous shifting, 2'b01 the 10-bit frame, 2'b10 the 11-bit frame; 2'b11 is reserved and holds `tx_ready` low.
- R2: In mode 0 a transmit handshake drives the byte on `rxd_out` with `rxd_oe` high, bit 0 first. It emits 8 shift clocks on `txd`, each 12 core cycles long: low for the first 6 cycles and high for the last 6. Each bit is valid at its rising edge. `ti` is set after the eighth clock.
- R3: In mode 0, with `ren`=1 and `rx_valid`=0, the port emits 8 shift clocks and samples `rxd_in` at each rising edge, bit 0 first. It then presents the byte with `rx_valid` set.
- R4: In mode 1 a frame is a 0 start bit, 8 data bits LSB first and a 1 stop bit. Each bit lasts 16 `baud_tick_tx` pulses, and `ti` is set at the end of the stop bit.
- R5: In mode 2 a frame is a start bit, 8 data bits, `tb8`, then a stop bit. Each bit lasts 64 core cycles, or 32 when `smod`=1, in both directions.
- R6: Asynchronous reception starts on a 1-to-0 edge of `rxd_in`. Each bit is oversampled 16 times and decided by a 2-of-3 vote near mid-bit. A start bit that votes high is dropped without effect.
- R7: A completed asynchronous frame is discarded, leaving `rx_valid`, `rx_data` and `rb8` unchanged, if `rx_valid` is already 1, or if `sm2`=1 and the last voted bit (the ninth bit in mode 2, the stop bit in mode 1) is 0.
- R8: An accepted asynchronous frame loads the 8 data bits into `rx_data` and the ninth bit (mode 2) or stop bit (mode 1) into `rb8`, and raises `rx_valid`.
- R9: `rx_valid` and `rx_data` hold until a cycle with `rx_valid && rx_ready`, which clears `rx_valid`.
- R10: `tx_ready` is high only while idle. A `tx_valid && tx_ready` cycle starts a frame and drops `tx_ready`. `ti` stays set until `ti_clr`.
- R11: After reset `txd`=1, `rxd_oe`=0, `ti`=0, `rx_valid`=0, and `tx_ready`=1 in any non-reserved mode.
- R12: With `ren`=0 no asynchronous frame is received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset |
| mode | input | 2 | Frame mode select |
| ren | input | 1 | Receive enable |
| sm2 | input | 1 | Ninth-bit acceptance filter enable |
| tb8 | input | 1 | Ninth bit to send in mode 2 |
| smod | input | 1 | Doubles the mode 2 rate |
| baud_tick_tx | input | 1 | Mode 1 transmit tick, 16 per bit |
| baud_tick_rx | input | 1 | Mode 1 receive tick, 16 per bit |
| tx_valid | input | 1 | Transmit byte offered |
| tx_data | input | DW | Transmit byte |
| tx_ready | output | 1 | Port idle, byte will be taken |
| ti | output | 1 | Transmit-complete flag |
| ti_clr | input | 1 | Clears `ti` |
| rx_valid | output | 1 | Received byte held (receive flag) |
| rx_data | output | DW | Received byte |
| rx_ready | input | 1 | Consumes the held byte |
| rb8 | output | 1 | Received ninth or stop bit |
| rxd_in | input | 1 | Serial data in |
| rxd_out | output | 1 | Mode 0 data out |
| rxd_oe | output | 1 | Mode 0 data-pin drive enable |
| txd | output | 1 | Async data out or mode 0 shift clock |

## Verification
A bit counter that is off by one shows on `txd` as a frame one bit too long or too short. The receive side then sees a shifted byte or a missing stop bit. Either error appears within a single frame time, and the `ti` timing check catches it within a few cycles. A faulty vote or acceptance gate shows as a byte that arrives when it should have been dropped, or a byte that never arrives. The scoreboard reports this at the end of the frame in question. A receive flag that fails to hold shows as `rx_data` changing under a pending byte on the next frame.

// File: rtl/serial_pkg.sv
package serial_pkg;
  typedef enum logic [1:0] {
    MODE_SHIFT = 2'b00,
    MODE_UART8 = 2'b01,
    MODE_UART9 = 2'b10,
    MODE_RSVD  = 2'b11
  } sp_mode_e;

  typedef enum logic [1:0] {
    SS_IDLE = 2'd0,
    SS_TX   = 2'd1,
    SS_RX   = 2'd2
  } ss_state_e;
endpackage

// File: rtl/sp_rate_gen.sv
module sp_rate_gen #(
  parameter int OVS    = 16,
  parameter int M2_DIV = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       smod,
  input  logic       ext_tick_tx,
  input  logic       ext_tick_rx,
  output logic       tick_tx,
  output logic       tick_rx
);
  import serial_pkg::*;

  localparam int FULL = (M2_DIV / OVS > 1) ? M2_DIV / OVS : 2;
  localparam int HALF = (FULL / 2 > 0) ? FULL / 2 : 1;
  localparam int CW   = $clog2(FULL);

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;
  logic          m2_tick;

  assign lim     = smod ? CW'(HALF - 1) : CW'(FULL - 1);
  assign m2_tick = (cnt >= lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= m2_tick ? '0 : cnt + 1'b1;
  end

  always_comb begin
    unique case (sp_mode_e'(mode))
      MODE_UART8: begin tick_tx = ext_tick_tx; tick_rx = ext_tick_rx; end
      MODE_UART9: begin tick_tx = m2_tick;     tick_rx = m2_tick;     end
      default:    begin tick_tx = 1'b0;        tick_rx = 1'b0;        end
    endcase
  end
endmodule

// File: rtl/sp_async_tx.sv
module sp_async_tx #(
  parameter int OVS = 16,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          start,
  input  logic          nine,
  input  logic [DW-1:0] data,
  input  logic          bit9,
  output logic          busy,
  output logic          txd,
  output logic          done
);
  localparam int FW  = DW + 3;
  localparam int OCW = $clog2(OVS);
  localparam int BCW = $clog2(FW + 1);

  logic [FW-1:0]  sreg;
  logic [OCW-1:0] ocnt;
  logic [BCW-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg <= '1;
      ocnt <= '0;
      left <= '0;
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        sreg <= {1'b1, (nine ? bit9 : 1'b1), data, 1'b0};
        left <= nine ? BCW'(FW) : BCW'(FW - 1);
        ocnt <= '0;
        busy <= 1'b1;
      end else if (busy && tick) begin
        if (ocnt == OCW'(OVS - 1)) begin
          ocnt <= '0;
          sreg <= {1'b1, sreg[FW-1:1]};
          left <= left - 1'b1;
          if (left == BCW'(1)) begin
            busy <= 1'b0;
            done <= 1'b1;
          end
        end else begin
          ocnt <= ocnt + 1'b1;
        end
      end
    end
  end

  assign txd = busy ? sreg[0] : 1'b1;
endmodule

// File: rtl/sp_async_rx.sv
module sp_async_rx #(
  parameter int OVS = 16,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          enable,
  input  logic          rxd,
  output logic          done,
  output logic [DW-1:0] data,
  output logic          bit9
);
  localparam int MID = OVS / 2;
  localparam int OCW = $clog2(OVS);
  localparam int BCW = $clog2(DW + 2);

  logic           active, prev, s_a, s_b;
  logic [DW:0]    sreg;
  logic [OCW-1:0] ocnt;
  logic [BCW-1:0] bidx;
  logic           vote;
  logic [DW:0]    nxt;

  // 2-of-3 majority: two earlier samples plus the current one
  assign vote = (s_a & s_b) | (s_a & rxd) | (s_b & rxd);
  assign nxt  = {vote, sreg[DW:1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      prev   <= 1'b1;
      s_a    <= 1'b0;
      s_b    <= 1'b0;
      sreg   <= '0;
      ocnt   <= '0;
      bidx   <= '0;
      done   <= 1'b0;
      data   <= '0;
      bit9   <= 1'b0;
    end else begin
      done <= 1'b0;
      prev <= rxd;
      if (!active) begin
        if (enable && prev && !rxd) begin
          active <= 1'b1;
          ocnt   <= '0;
          bidx   <= '0;
        end
      end else if (!enable) begin
        active <= 1'b0;
      end else if (tick) begin
        if (ocnt == OCW'(OVS - 1)) begin
          ocnt <= '0;
          bidx <= bidx + 1'b1;
        end else begin
          ocnt <= ocnt + 1'b1;
        end
        if (ocnt == OCW'(MID - 1)) s_a <= rxd;
        if (ocnt == OCW'(MID))     s_b <= rxd;
        if (ocnt == OCW'(MID + 1)) begin
          if (bidx == '0) begin
            if (vote) active <= 1'b0;
          end else begin
            sreg <= nxt;
            if (bidx == BCW'(DW + 1)) begin
              active <= 1'b0;
              done   <= 1'b1;
              data   <= nxt[DW-1:0];
              bit9   <= nxt[DW];
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/sp_sync_shift.sv
module sp_sync_shift #(
  parameter int DIV = 12,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_start,
  input  logic [DW-1:0] tx_data,
  input  logic          rx_start,
  input  logic          rxd,
  output logic          busy,
  output logic          sclk,
  output logic          dout,
  output logic          doe,
  output logic          tx_done,
  output logic          rx_done,
  output logic [DW-1:0] rx_data
);
  import serial_pkg::*;

  localparam int HALF = DIV / 2;
  localparam int CW   = $clog2(DIV);
  localparam int BW   = (DW > 1) ? $clog2(DW) : 1;

  ss_state_e     state;
  logic [CW-1:0] cyc;
  logic [BW-1:0] bcnt;
  logic [DW-1:0] sreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= SS_IDLE;
      cyc     <= '0;
      bcnt    <= '0;
      sreg    <= '0;
      tx_done <= 1'b0;
      rx_done <= 1'b0;
    end else begin
      tx_done <= 1'b0;
      rx_done <= 1'b0;
      if (state == SS_IDLE) begin
        cyc  <= '0;
        bcnt <= '0;
        if (tx_start) begin
          state <= SS_TX;
          sreg  <= tx_data;
        end else if (rx_start) begin
          state <= SS_RX;
        end
      end else begin
        if (state == SS_RX && cyc == CW'(HALF)) sreg <= {rxd, sreg[DW-1:1]};
        if (cyc == CW'(DIV - 1)) begin
          cyc <= '0;
          if (state == SS_TX) sreg <= {1'b0, sreg[DW-1:1]};
          if (bcnt == BW'(DW - 1)) begin
            if (state == SS_TX) tx_done <= 1'b1;
            else                rx_done <= 1'b1;
            state <= SS_IDLE;
          end else begin
            bcnt <= bcnt + 1'b1;
          end
        end else begin
          cyc <= cyc + 1'b1;
        end
      end
    end
  end

  assign busy    = (state != SS_IDLE);
  assign sclk    = busy ? (cyc >= CW'(HALF)) : 1'b1;
  assign doe     = (state == SS_TX);
  assign dout    = doe ? sreg[0] : 1'b1;
  assign rx_data = sreg;
endmodule

// File: rtl/mcu_serial_port.sv
module mcu_serial_port #(
  parameter int DW       = 8,
  parameter int OVS      = 16,
  parameter int SYNC_DIV = 12,
  parameter int M2_DIV   = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode,
  input  logic          ren,
  input  logic          sm2,
  input  logic          tb8,
  input  logic          smod,
  input  logic          baud_tick_tx,
  input  logic          baud_tick_rx,
  input  logic          tx_valid,
  input  logic [DW-1:0] tx_data,
  output logic          tx_ready,
  output logic          ti,
  input  logic          ti_clr,
  output logic          rx_valid,
  output logic [DW-1:0] rx_data,
  input  logic          rx_ready,
  output logic          rb8,
  input  logic          rxd_in,
  output logic          rxd_out,
  output logic          rxd_oe,
  output logic          txd
);
  import serial_pkg::*;

  sp_mode_e      m;
  logic          is_sync, is_async;
  logic          rs1, rs2;
  logic          tick_tx, tick_rx;
  logic          tx_fire;
  logic          s_busy, s_sclk, s_dout, s_doe, s_tx_done, s_rx_done;
  logic [DW-1:0] s_rx_data;
  logic          a_tx_busy, a_txd, a_tx_done;
  logic          a_rx_done, a_bit9;
  logic [DW-1:0] a_rx_data;
  logic          a_accept, s_accept;
  logic          ri;

  assign m        = sp_mode_e'(mode);
  assign is_sync  = (m == MODE_SHIFT);
  assign is_async = (m == MODE_UART8) || (m == MODE_UART9);

  // two-flop synchronizer on the incoming data pin
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin rs1 <= 1'b1; rs2 <= 1'b1; end
    else        begin rs1 <= rxd_in; rs2 <= rs1; end
  end

  assign tx_ready = !s_busy && !a_tx_busy && (m != MODE_RSVD);
  assign tx_fire  = tx_valid && tx_ready;

  sp_rate_gen #(.OVS(OVS), .M2_DIV(M2_DIV)) u_rate (
    .clk(clk), .rst_n(rst_n), .mode(mode), .smod(smod),
    .ext_tick_tx(baud_tick_tx), .ext_tick_rx(baud_tick_rx),
    .tick_tx(tick_tx), .tick_rx(tick_rx)
  );

  sp_sync_shift #(.DIV(SYNC_DIV), .DW(DW)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .tx_start(tx_fire && is_sync), .tx_data(tx_data),
    .rx_start(is_sync && ren && !ri && !s_rx_done), .rxd(rs2),
    .busy(s_busy), .sclk(s_sclk), .dout(s_dout), .doe(s_doe),
    .tx_done(s_tx_done), .rx_done(s_rx_done), .rx_data(s_rx_data)
  );

  sp_async_tx #(.OVS(OVS), .DW(DW)) u_atx (
    .clk(clk), .rst_n(rst_n), .tick(tick_tx),
    .start(tx_fire && is_async), .nine(m == MODE_UART9),
    .data(tx_data), .bit9(tb8),
    .busy(a_tx_busy), .txd(a_txd), .done(a_tx_done)
  );

  sp_async_rx #(.OVS(OVS), .DW(DW)) u_arx (
    .clk(clk), .rst_n(rst_n), .tick(tick_rx),
    .enable(is_async && ren), .rxd(rs2),
    .done(a_rx_done), .data(a_rx_data), .bit9(a_bit9)
  );

  // acceptance gate: flag must be free; with the filter on, bit 9 must be 1
  assign a_accept = a_rx_done && !ri && (!sm2 || a_bit9);
  assign s_accept = s_rx_done && !ri;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ri      <= 1'b0;
      rx_data <= '0;
      rb8     <= 1'b0;
      ti      <= 1'b0;
    end else begin
      if (a_accept) begin
        ri      <= 1'b1;
        rx_data <= a_rx_data;
        rb8     <= a_bit9;
      end else if (s_accept) begin
        ri      <= 1'b1;
        rx_data <= s_rx_data;
      end else if (ri && rx_ready) begin
        ri <= 1'b0;
      end
      if (s_tx_done || a_tx_done) ti <= 1'b1;
      else if (ti_clr)            ti <= 1'b0;
    end
  end

  assign rx_valid = ri;
  assign rxd_out  = s_dout;
  assign rxd_oe   = s_doe && is_sync;
  assign txd      = s_sclk & a_txd;
endmodule

// File: rtl/sp_checker.sv
module sp_checker #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    mode,
  input logic          sm2,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic          ti,
  input logic          ti_clr,
  input logic          rx_valid,
  input logic [DW-1:0] rx_data,
  input logic          rx_ready,
  input logic          rb8,
  input logic          rxd_oe,
  input logic          txd
);
  assert_rx_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data) && $stable(rb8)));

  assert_take_drops_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready);

  assert_ti_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ti && !ti_clr) |=> ti);

  assert_idle_line_high_R11: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> txd);

  assert_drive_only_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rxd_oe |-> !tx_ready);

  assert_filter_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rx_valid) && $past(sm2) && ($past(mode) != 2'b00)) |-> rb8);
endmodule

bind mcu_serial_port sp_checker #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .sm2(sm2),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .ti(ti), .ti_clr(ti_clr),
  .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready), .rb8(rb8),
  .rxd_oe(rxd_oe), .txd(txd)
);

// File: tb/sim_mcu_serial_port.sv
module sim_mcu_serial_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'b01;
  logic       ren = 1'b0, sm2 = 1'b0, tb8 = 1'b0, smod = 1'b0;
  logic       tick = 1'b0;
  logic       tx_valid = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic       tx_ready, ti, rx_valid, rb8, rxd_out, rxd_oe, txd;
  logic       ti_clr = 1'b0;
  logic [7:0] rx_data;
  logic       rx_ready = 1'b0;
  logic       rxd_in = 1'b1;

  int  checks = 0, failures = 0;
  int  bp = 80;
  bit  mon_tx_en = 1'b0, mon_rx_en = 1'b0;
  logic [8:0] txq[$];
  logic [9:0] rxq[$];

  mcu_serial_port u0 (
    .clk(clk), .rst_n(rst_n), .mode(mode), .ren(ren), .sm2(sm2), .tb8(tb8),
    .smod(smod), .baud_tick_tx(tick), .baud_tick_rx(tick),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready), .ti(ti),
    .ti_clr(ti_clr), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_ready(rx_ready), .rb8(rb8), .rxd_in(rxd_in), .rxd_out(rxd_out),
    .rxd_oe(rxd_oe), .txd(txd)
  );

  always #2 clk = ~clk;

  // mode 1 oversampling tick: one pulse every 5 cycles -> 80-cycle bits
  initial forever begin
    repeat (4) @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL R10 watchdog actual=%0d expected=%0d", 150000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  // transmit monitor: decodes async frames on txd and pops the scoreboard
  initial begin
    logic p;
    p = 1'b1;
    forever begin
      @(negedge clk);
      if (mon_tx_en && p && !txd) begin
        logic [7:0] d;
        logic n9, st, s0;
        bit nine;
        nine = (mode == 2'b10);
        n9 = 1'b1;
        repeat (bp / 2) @(negedge clk);
        s0 = txd;
        for (int i = 0; i < 8; i++) begin
          repeat (bp) @(negedge clk);
          d[i] = txd;
        end
        if (nine) begin
          repeat (bp) @(negedge clk);
          n9 = txd;
        end
        repeat (bp) @(negedge clk);
        st = txd;
        check(s0 == 1'b0, nine ? "R5 start" : "R4 start", s0, 0);
        check(st == 1'b1, nine ? "R5 stop" : "R4 stop", st, 1);
        if (txq.size() == 0) begin
          check(1'b0, "R10 unexpected tx frame", d, 0);
        end else begin
          logic [8:0] e;
          e = txq.pop_front();
          check(d == e[7:0], nine ? "R5 data" : "R4 data", d, e[7:0]);
          if (nine) check(n9 == e[8], "R5 ninth", n9, e[8]);
        end
      end
      p = txd;
    end
  end

  // receive monitor: consumes held bytes and compares with the scoreboard
  initial forever begin
    @(negedge clk);
    if (mon_rx_en && rx_valid && !rx_ready) begin
      if (rxq.size() == 0) begin
        check(1'b0, "R7 unexpected rx byte", rx_data, 0);
      end else begin
        logic [9:0] e;
        e = rxq.pop_front();
        check(rx_data == e[7:0], "R8 data", rx_data, e[7:0]);
        if (e[9]) check(rb8 == e[8], "R8 rb8", rb8, e[8]);
      end
      rx_ready = 1'b1;
      @(negedge clk);
      rx_ready = 1'b0;
    end
  end

  task automatic send_async(input logic [7:0] d, input logic n9, input int bits, input string tag);
    int n;
    txq.push_back({n9, d});
    while (!tx_ready) @(negedge clk);
    tx_data = d; tb8 = n9; tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    check(tx_ready == 1'b0, "R10 busy", tx_ready, 0);
    n = 1;
    while (!ti && n < 5000) begin @(negedge clk); n++; end
    check((n >= bits * bp - 8) && (n <= bits * bp + 8), tag, n, bits * bp);
    repeat (30) @(negedge clk);
    check(ti == 1'b1, "R10 ti sticky", ti, 1);
    ti_clr = 1'b1; @(negedge clk); ti_clr = 1'b0; @(negedge clk);
    check(ti == 1'b0, "R10 ti clear", ti, 0);
    n = 0;
    while (txq.size() != 0 && n < 2000) begin @(negedge clk); n++; end
    check(txq.size() == 0, tag, txq.size(), 0);
  endtask

  task automatic drive_frame(input logic [7:0] d, input logic n9, input bit use9);
    rxd_in = 1'b0;
    repeat (bp) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd_in = d[i];
      repeat (bp) @(negedge clk);
    end
    if (use9) begin
      rxd_in = n9;
      repeat (bp) @(negedge clk);
    end
    rxd_in = 1'b1;
    repeat (bp) @(negedge clk);
  endtask

  task automatic wait_rx_empty(input string tag);
    int n;
    n = 0;
    while (rxq.size() != 0 && n < 3000) begin @(negedge clk); n++; end
    check(rxq.size() == 0, tag, rxq.size(), 0);
    repeat (4) @(negedge clk);
  endtask

  task automatic wait_txd_edge(input bit rise, output int n);
    logic p;
    p = txd;
    n = 0;
    forever begin
      @(negedge clk);
      n++;
      if ((rise && !p && txd) || (!rise && p && !txd) || n > 1000) break;
      p = txd;
    end
  endtask

  initial begin
    int n;
    logic [7:0] got;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11: idle state after reset
    check(txd == 1'b1, "R11 txd", txd, 1);
    check(rxd_oe == 1'b0, "R11 oe", rxd_oe, 0);
    check(ti == 1'b0, "R11 ti", ti, 0);
    check(rx_valid == 1'b0, "R11 rx_valid", rx_valid, 0);
    check(tx_ready == 1'b1, "R11 tx_ready", tx_ready, 1);

    // transmit, modes 1 and 2
    mon_tx_en = 1'b1;
    mode = 2'b01; bp = 80;
    send_async(8'h3C, 1'b1, 10, "R4 frame time");
    mode = 2'b10; bp = 64; smod = 1'b0;
    send_async(8'h96, 1'b1, 11, "R5 frame time /64");
    smod = 1'b1; bp = 32;
    send_async(8'h41, 1'b0, 11, "R5 frame time /32");
    mon_tx_en = 1'b0;

    // receive, mode 1
    mon_rx_en = 1'b1;
    mode = 2'b01; bp = 80; smod = 1'b0; ren = 1'b1; sm2 = 1'b0;
    repeat (20) @(negedge clk);
    rxq.push_back({1'b1, 1'b1, 8'h5A});
    drive_frame(8'h5A, 1'b0, 1'b0);
    wait_rx_empty("R8 mode1 byte");
    ren = 1'b0;
    drive_frame(8'h33, 1'b0, 1'b0);
    repeat (20) @(negedge clk);
    check(rx_valid == 1'b0, "R12 ren off", rx_valid, 0);
    ren = 1'b1;
    rxd_in = 1'b0; repeat (20) @(negedge clk); rxd_in = 1'b1;
    repeat (120) @(negedge clk);
    check(rx_valid == 1'b0, "R6 false start", rx_valid, 0);
    rxq.push_back({1'b1, 1'b1, 8'hC3});
    drive_frame(8'hC3, 1'b0, 1'b0);
    wait_rx_empty("R6 after glitch");

    // receive, mode 2 with the filter
    mode = 2'b10; bp = 64; sm2 = 1'b1;
    repeat (20) @(negedge clk);
    drive_frame(8'h44, 1'b0, 1'b1);
    repeat (20) @(negedge clk);
    check(rx_valid == 1'b0, "R7 filtered data frame", rx_valid, 0);
    rxq.push_back({1'b1, 1'b1, 8'h21});
    drive_frame(8'h21, 1'b1, 1'b1);
    wait_rx_empty("R7 address frame");
    sm2 = 1'b0;
    rxq.push_back({1'b1, 1'b0, 8'h77});
    drive_frame(8'h77, 1'b0, 1'b1);
    wait_rx_empty("R8 ninth bit");
    smod = 1'b1; bp = 32;
    rxq.push_back({1'b1, 1'b1, 8'h9E});
    drive_frame(8'h9E, 1'b1, 1'b1);
    wait_rx_empty("R5 fast rx");
    smod = 1'b0;

    // overrun: a held byte blocks the next frame
    mon_rx_en = 1'b0;
    mode = 2'b01; bp = 80;
    repeat (20) @(negedge clk);
    drive_frame(8'h11, 1'b0, 1'b0);
    repeat (20) @(negedge clk);
    check(rx_valid == 1'b1, "R9 held", rx_valid, 1);
    drive_frame(8'h22, 1'b0, 1'b0);
    repeat (20) @(negedge clk);
    check(rx_valid == 1'b1, "R9 still held", rx_valid, 1);
    check(rx_data == 8'h11, "R7 overrun dropped", rx_data, 8'h11);
    rx_ready = 1'b1; @(negedge clk); rx_ready = 1'b0;
    check(rx_valid == 1'b0, "R9 consumed", rx_valid, 0);

    // mode 0 transmit
    ren = 1'b0; mode = 2'b00;
    @(negedge clk);
    tx_data = 8'hA5; tx_valid = 1'b1; @(negedge clk); tx_valid = 1'b0;
    for (int i = 0; i < 8; i++) begin
      wait_txd_edge(1'b1, n);
      if (i > 0) check(n == 12, "R2 clock period", n, 12);
      if (i == 0) check(rxd_oe == 1'b1, "R1 sync mode drives pin", rxd_oe, 1);
      got[i] = rxd_out;
    end
    check(got == 8'hA5, "R2 shifted byte", got, 8'hA5);
    repeat (10) @(negedge clk);
    check(ti == 1'b1, "R2 ti", ti, 1);
    check(rxd_oe == 1'b0, "R2 release", rxd_oe, 0);
    ti_clr = 1'b1; @(negedge clk); ti_clr = 1'b0;

    // mode 0 receive
    rxd_in = 1'b0;
    ren = 1'b1;
    for (int k = 0; k < 8; k++) begin
      wait_txd_edge(1'b0, n);
      rxd_in = 8'h6E >> k;
    end
    n = 0;
    while (!rx_valid && n < 300) begin @(negedge clk); n++; end
    ren = 1'b0;
    check(rx_valid == 1'b1, "R3 flag", rx_valid, 1);
    check(rx_data == 8'h6E, "R3 byte", rx_data, 8'h6E);
    rx_ready = 1'b1; @(negedge clk); rx_ready = 1'b0;
    rxd_in = 1'b1;

    // reserved mode
    mode = 2'b11;
    @(negedge clk);
    check(tx_ready == 1'b0, "R1 reserved", tx_ready, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule